// File: doc/BRIEF.md
# Wide-Access Byte FIFO Link Bridge

This block joins a 32-bit host register port to a byte-wide link. Bytes the host writes go into a transmit FIFO, and the link transmitter drains that FIFO one byte per valid/ready handshake. Bytes the link receiver delivers go into a receive FIFO, and host reads drain it. The host can move data one byte at a time at a legacy-compatible offset. It can also move two or four bytes per access at a packed offset. Packed writes are split into bytes with the least significant byte sent first. Packed reads gather the oldest received byte into the least significant lane.

Software reads the fill level of each FIFO before a bulk transfer, so it knows how much room or data there is. A control register drives a reset line to the attached module and empties both FIFOs. Two sticky flags record a rejected write (overflow) and a short read (underflow). Every host access is a single-cycle strobe. Write data is right-aligned in `host_wdata`. Read data appears on `host_rdata` in the cycle after the read strobe, marked by `host_rvalid`.

Top module: `link_fifo_bridge`

## Requirements
- R1: A write to offset 0x01 with byte enables 4'b0001 pushes `host_wdata[7:0]` into the transmit FIFO. The link side offers FIFO bytes in arrival order: `tx_valid` is high whenever a byte is held, and a byte leaves on each cycle with `tx_valid` and `tx_ready` both high.
- R2: A read at offset 0x01 with byte enables 4'b0001 removes the oldest received byte and returns it in `host_rdata[7:0]`, with the upper bits zero. `host_rvalid` is high in the cycle after the strobe.
- R3: A write to offset 0x1C with byte enables 4'b0011 pushes two bytes, and with 4'b1111 pushes four bytes. Bytes enter lowest lane first (`host_wdata[7:0]` first). Any other byte-enable pattern at 0x1C is ignored.
- R4: A read at offset 0x1C with byte enables 4'b0011 or 4'b1111 removes two or four bytes. The oldest byte is placed in bits [7:0], the next in [15:8], and so on.
- R5: A read of offset 0x14 (transmit) or 0x18 (receive) with byte enables 4'b0011 returns that FIFO's fill count in bits [15:0]. Any other byte-enable pattern returns zero.
- R6: A data write that does not fit in the free transmit space is discarded entirely, and it sets the overflow flag at bit 1 of offset 0x10. The flag stays set until software writes 0x10 with bit 1 set.
- R7: A data read that finds fewer bytes than it asks for takes every byte that is present and returns zero in the missing lanes. It also sets the underflow flag at bit 2 of offset 0x10, which stays set until software writes 0x10 with bit 2 set.
- R8: Bit 0 of offset 0x10 (written with `host_be[0]` set, read back at bit 0) drives `mod_reset`. While it is 1: both FIFOs are emptied, both levels read zero, `tx_valid` and `rx_ready` are low, and data writes are discarded without setting a flag. Writing 0 releases the reset.
- R9: Each FIFO holds DEPTH bytes (default 64). `rx_ready` is low when the receive FIFO is full, and a full FIFO reports level DEPTH.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and `tx_valid` stays high, unless the module reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 8 | Byte offset of the access |
| host_be | input | 4 | Byte enables; they also set the access size |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High in the cycle after a read strobe |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Link transmitter accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Link receiver offers a byte |
| rx_ready | output | 1 | Bridge accepts the received byte |
| rx_data | input | 8 | Received byte |
| mod_reset | output | 1 | Reset to the attached module |

## Verification
The transmit path is driven with byte writes, half-word writes and word writes, using distinct values in every lane. This exposes any lane swap or any error in unpack order. The receive path is read back with all three access sizes, both when enough bytes are present and when only some are present. This separates correct packing from zero-filling and from over-consumption. Directed runs fill each FIFO to exactly DEPTH and then try one more access, which checks the full-boundary reject and the level width. A reset pulse in the middle of a transfer shows that the flush and the discarded writes leave nothing behind. A seeded random mix of all operations is then compared against byte queues held in the bench.

// File: rtl/link_bridge_pkg.sv
package link_bridge_pkg;

  localparam logic [7:0] OFS_BYTE  = 8'h01;
  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_TXLVL = 8'h14;
  localparam logic [7:0] OFS_RXLVL = 8'h18;
  localparam logic [7:0] OFS_WIDE  = 8'h1C;

  localparam int unsigned LANES = 4;

  localparam logic [3:0] BE_BYTE = 4'b0001;
  localparam logic [3:0] BE_HALF = 4'b0011;
  localparam logic [3:0] BE_WORD = 4'b1111;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_BYTE,
    ACC_WIDE
  } acc_kind_e;

  // Number of bytes an access moves, from its byte enables
  function automatic logic [2:0] be_bytes(input logic [3:0] be);
    case (be)
      BE_BYTE: be_bytes = 3'd1;
      BE_HALF: be_bytes = 3'd2;
      BE_WORD: be_bytes = 3'd4;
      default: be_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lb_fifo.sv
module lb_fifo #(
  parameter int unsigned DEPTH  = 64,   // power of two
  parameter int unsigned PUSH_L = 1,
  parameter int unsigned POP_L  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [$clog2(PUSH_L+1)-1:0]   push_n,
  input  logic [PUSH_L*8-1:0]           push_data,
  input  logic [$clog2(POP_L+1)-1:0]    pop_n,
  output logic [POP_L*8-1:0]            pop_data,
  output logic [$clog2(DEPTH):0]        count
);

  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned CW  = AW + 1;
  localparam int unsigned PNW = $clog2(PUSH_L + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ptr_en;

  // next state
  always_comb begin
    if (flush) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      wptr_d  = wptr_q + AW'(push_n);
      rptr_d  = rptr_q + AW'(pop_n);
      count_d = count_q + CW'(push_n) - CW'(pop_n);
    end
    ptr_en = flush | (|push_n) | (|pop_n);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  // storage, one lane per pushed byte
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_L; i++) begin
      if (!flush && (push_n > PNW'(i))) begin
        mem[wptr_q + AW'(i)] <= push_data[i*8 +: 8];
      end
    end
  end

  generate
    for (genvar g = 0; g < POP_L; g++) begin : g_pop
      assign pop_data[g*8 +: 8] = mem[rptr_q + AW'(g)];
    end
  endgenerate

  assign count = count_q;

  // R9: a push never exceeds free room
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(count_q) + int'(push_n)) <= int'(DEPTH));

  // R7: a pop never takes more than is stored
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> int'(pop_n) <= int'(count_q));

  // R8: a flush leaves the FIFO empty
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count_q == '0);

endmodule

// File: rtl/lb_host_regs.sv
module lb_host_regs
  import link_bridge_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                host_addr,
  input  logic [3:0]                host_be,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [2:0]                ctl_wbits,
  output logic [31:0]               host_rdata,
  output logic                      host_rvalid,
  input  logic [$clog2(DEPTH):0]    tx_count,
  input  logic [$clog2(DEPTH):0]    rx_count,
  input  logic [LANES*8-1:0]        rx_pop_data,
  output logic [2:0]                tx_push_n,
  output logic [2:0]                rx_pop_n,
  output logic                      ctl_rst
);

  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  acc_kind_e     kind;
  logic [2:0]    req_n;
  logic          data_wr, data_rd, ctrl_wr;
  logic [CW-1:0] tx_free, rx_avail, tx_lvl, rx_lvl;
  logic [2:0]    take;
  logic          ovf_set, udf_set;
  logic [31:0]   rd_pack, rdata_d;

  logic          ctl_q, ovf_q, udf_q;
  logic          ctl_d, ovf_d, udf_d;
  logic [31:0]   rdata_q;
  logic          rvalid_q;

  // decode
  always_comb begin
    if (host_addr == OFS_BYTE && host_be == BE_BYTE) begin
      kind = ACC_BYTE;
    end else if (host_addr == OFS_WIDE && (host_be == BE_HALF || host_be == BE_WORD)) begin
      kind = ACC_WIDE;
    end else begin
      kind = ACC_NONE;
    end
    req_n   = (kind == ACC_NONE) ? 3'd0 : be_bytes(host_be);
    data_wr = host_wr && (kind != ACC_NONE);
    data_rd = host_rd && !host_wr && (kind != ACC_NONE);
    ctrl_wr = host_wr && (host_addr == OFS_CTRL) && host_be[0];
  end

  // FIFO room and data, gated by the module reset
  always_comb begin
    tx_lvl   = ctl_q ? '0 : tx_count;
    rx_lvl   = ctl_q ? '0 : rx_count;
    tx_free  = DEPTH_C - tx_lvl;
    rx_avail = rx_lvl;

    ovf_set   = data_wr && !ctl_q && (CW'(req_n) > tx_free);
    tx_push_n = (data_wr && !ctl_q && !ovf_set) ? req_n : 3'd0;

    if (CW'(req_n) <= rx_avail) begin
      take = req_n;
    end else begin
      take = rx_avail[2:0];
    end
    udf_set  = data_rd && (CW'(req_n) > rx_avail);
    rx_pop_n = data_rd ? take : 3'd0;
  end

  // read data assembly
  always_comb begin
    rd_pack = '0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < take) begin
        rd_pack[i*8 +: 8] = rx_pop_data[i*8 +: 8];
      end
    end
    rdata_d = '0;
    if (data_rd) begin
      rdata_d = rd_pack;
    end else if (host_addr == OFS_CTRL) begin
      rdata_d = {29'd0, udf_q, ovf_q, ctl_q};
    end else if (host_addr == OFS_TXLVL && host_be == BE_HALF) begin
      rdata_d = {16'd0, 16'(tx_lvl)};
    end else if (host_addr == OFS_RXLVL && host_be == BE_HALF) begin
      rdata_d = {16'd0, 16'(rx_lvl)};
    end
  end

  // control and sticky next state
  always_comb begin
    ctl_d = ctrl_wr ? ctl_wbits[0] : ctl_q;
    ovf_d = ovf_q;
    udf_d = udf_q;
    if (ctrl_wr && ctl_wbits[1]) ovf_d = 1'b0;
    if (ctrl_wr && ctl_wbits[2]) udf_d = 1'b0;
    if (ovf_set) ovf_d = 1'b1;
    if (udf_set) udf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= 1'b0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ctl_q    <= ctl_d;
      ovf_q    <= ovf_d;
      udf_q    <= udf_d;
      rvalid_q <= host_rd;
      if (host_rd) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign ctl_rst     = ctl_q;

  // R6: overflow flag holds until cleared by software
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(ctrl_wr && ctl_wbits[1]) |=> ovf_q);

  // R7: underflow flag holds until cleared by software
  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q && !(ctrl_wr && ctl_wbits[2]) |=> udf_q);

  // R2: read data is marked valid one cycle after the strobe
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

endmodule

// File: rtl/link_fifo_bridge.sv
module link_fifo_bridge
  import link_bridge_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  host_addr,
  input  logic [3:0]  host_be,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rvalid,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        mod_reset
);

  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [1:0]          rst_sync_q;
  logic                rst_ns;
  logic                ctl_rst;
  logic [2:0]          tx_push_n, rx_pop_n;
  logic [CW-1:0]       tx_count, rx_count;
  logic [7:0]          tx_head;
  logic [LANES*8-1:0]  rx_pop_data;
  logic                tx_pop, rx_push;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  lb_host_regs #(.DEPTH(DEPTH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_ns),
    .host_addr   (host_addr),
    .host_be     (host_be),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .ctl_wbits   (host_wdata[2:0]),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .rx_pop_data (rx_pop_data),
    .tx_push_n   (tx_push_n),
    .rx_pop_n    (rx_pop_n),
    .ctl_rst     (ctl_rst)
  );

  // link handshakes
  always_comb begin
    tx_valid = !ctl_rst && (tx_count != '0);
    tx_pop   = tx_valid && tx_ready;
    rx_ready = !ctl_rst && (rx_count != DEPTH_C);
    rx_push  = rx_valid && rx_ready;
  end

  lb_fifo #(.DEPTH(DEPTH), .PUSH_L(LANES), .POP_L(1)) u_txq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .flush     (ctl_rst),
    .push_n    (tx_push_n),
    .push_data (host_wdata),
    .pop_n     (tx_pop),
    .pop_data  (tx_head),
    .count     (tx_count)
  );

  lb_fifo #(.DEPTH(DEPTH), .PUSH_L(1), .POP_L(LANES)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .flush     (ctl_rst),
    .push_n    (rx_push),
    .push_data (rx_data),
    .pop_n     (rx_pop_n),
    .pop_data  (rx_pop_data),
    .count     (rx_count)
  );

  assign tx_data   = tx_head;
  assign mod_reset = ctl_rst;

  // R10: a stalled transmit byte stays put unless reset is being written
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_valid && !tx_ready && !(host_wr && host_addr == OFS_CTRL && host_be[0] && host_wdata[0])
    |=> tx_valid && $stable(tx_data));

endmodule

// File: tb/link_fifo_bridge_tb.sv
module link_fifo_bridge_tb;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic [3:0]  host_be;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        mod_reset;

  int checks = 0;
  int failures = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic       ovf_m, udf_m;

  always #5 clk = ~clk;

  link_fifo_bridge #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_be(host_be), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .mod_reset(mod_reset)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_be = be; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_addr = a; host_be = be; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
    v = host_rvalid;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(tx_valid == 1'b1, tag, {31'd0, tx_valid}, 32'd1);
    chk(tx_data == exp, tag, {24'd0, tx_data}, {24'd0, exp});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] status_exp(input logic rst_bit);
    return {29'd0, udf_m, ovf_m, rst_bit};
  endfunction

  // expected packed read from the bench queue, lowest lane oldest
  task automatic model_read(input int n, output logic [31:0] exp);
    exp = '0;
    for (int i = 0; i < n; i++) begin
      if (rxq.size() > 0) exp[i*8 +: 8] = rxq.pop_front();
      else udf_m = 1'b1;
    end
  endtask

  task automatic model_write(input int n, input logic [31:0] d);
    if (txq.size() + n <= DEPTH) begin
      for (int i = 0; i < n; i++) txq.push_back(d[i*8 +: 8]);
    end else begin
      ovf_m = 1'b1;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    logic        v;
    void'($urandom(32'd13579));
    rst_n = 1'b0; host_addr = '0; host_be = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    ovf_m = 1'b0; udf_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(tx_valid == 1'b0, "R1 reset tx_valid", {31'd0, tx_valid}, 0);
    chk(rx_ready == 1'b1, "R9 reset rx_ready", {31'd0, rx_ready}, 1);
    chk(mod_reset == 1'b0, "R8 reset mod_reset", {31'd0, mod_reset}, 0);
    bus_read(8'h10, 4'b1111, d, v);
    chk(d == 32'd0, "R8 reset status", d, 0);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == 32'd0, "R5 reset tx level", d, 0);

    // R1 byte writes, R10 stall
    bus_write(8'h01, 4'b0001, 32'hFFFF_FFA5);
    bus_write(8'h01, 4'b0001, 32'h0000_003C);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == 32'd2, "R5 tx level two", d, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 8'hA5, "R10 stalled byte held", {23'd0, tx_valid, tx_data}, 32'h1A5);
    end
    tx_take(8'hA5, "R1 first byte");
    tx_take(8'h3C, "R1 second byte");
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1 drained", {31'd0, tx_valid}, 0);

    // R3 wide writes
    bus_write(8'h1C, 4'b1111, 32'h4433_2211);
    bus_write(8'h1C, 4'b0011, 32'h9999_BEEF);
    bus_write(8'h1C, 4'b0111, 32'h7777_7777);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == 32'd6, "R3 odd enables ignored", d, 6);
    tx_take(8'h11, "R3 lane0"); tx_take(8'h22, "R3 lane1");
    tx_take(8'h33, "R3 lane2"); tx_take(8'h44, "R3 lane3");
    tx_take(8'hEF, "R3 half lane0"); tx_take(8'hBE, "R3 half lane1");

    // R9 fill transmit, R6 overflow
    for (int k = 0; k < DEPTH / 4; k++) bus_write(8'h1C, 4'b1111, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == DEPTH, "R9 tx full level", d, DEPTH);
    bus_write(8'h01, 4'b0001, 32'h55);
    bus_read(8'h10, 4'b1111, d, v);
    chk(d == 32'd2, "R6 overflow flag", d, 2);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == DEPTH, "R6 rejected write left level", d, DEPTH);
    bus_write(8'h10, 4'b0001, 32'h2);
    bus_read(8'h10, 4'b1111, d, v);
    chk(d == 32'd0, "R6 flag cleared", d, 0);
    for (int k = 0; k < DEPTH; k++) tx_take(8'(k), "R9 full drain order");

    // R9 fill receive, R4 packed reads, R5 wrong size
    for (int k = 0; k < DEPTH; k++) rx_send(8'(8'hC0 ^ k));
    @(negedge clk);
    chk(rx_ready == 1'b0, "R9 rx full ready low", {31'd0, rx_ready}, 0);
    bus_read(8'h18, 4'b0011, d, v);
    chk(d == DEPTH, "R9 rx full level", d, DEPTH);
    bus_read(8'h18, 4'b1111, d, v);
    chk(d == 32'd0, "R5 level needs half access", d, 0);
    for (int k = 0; k < DEPTH / 4; k++) begin
      bus_read(8'h1C, 4'b1111, d, v);
      e = {8'(8'hC0 ^ (4*k+3)), 8'(8'hC0 ^ (4*k+2)), 8'(8'hC0 ^ (4*k+1)), 8'(8'hC0 ^ (4*k))};
      chk(d == e, "R4 packed word", d, e);
    end

    // R2 byte read, R4 half read, R7 short read
    rx_send(8'h61); rx_send(8'h62); rx_send(8'h63); rx_send(8'h77);
    bus_read(8'h01, 4'b0001, d, v);
    chk(d == 32'h61 && v, "R2 byte read", d, 32'h61);
    bus_read(8'h1C, 4'b0011, d, v);
    chk(d == 32'h6362, "R4 half read", d, 32'h6362);
    bus_read(8'h1C, 4'b1111, d, v);
    chk(d == 32'h77, "R7 short read zero fill", d, 32'h77);
    bus_read(8'h10, 4'b1111, d, v);
    chk(d == 32'd4, "R7 underflow flag", d, 4);
    bus_read(8'h18, 4'b0011, d, v);
    chk(d == 32'd0, "R7 available bytes consumed", d, 0);
    bus_write(8'h10, 4'b0001, 32'h4);

    // R8 module reset
    bus_write(8'h01, 4'b0001, 32'h1); bus_write(8'h1C, 4'b0011, 32'h0302);
    rx_send(8'h10); rx_send(8'h11);
    bus_write(8'h10, 4'b0001, 32'h1);
    @(negedge clk);
    chk(mod_reset && !tx_valid && !rx_ready, "R8 reset holds link idle",
        {29'd0, mod_reset, tx_valid, rx_ready}, 32'h4);
    bus_write(8'h01, 4'b0001, 32'h55);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == 32'd0, "R8 tx level zero", d, 0);
    bus_read(8'h18, 4'b0011, d, v);
    chk(d == 32'd0, "R8 rx level zero", d, 0);
    bus_read(8'h10, 4'b1111, d, v);
    chk(d == 32'd1, "R8 status during reset", d, 1);
    bus_write(8'h10, 4'b0001, 32'h0);
    @(negedge clk);
    chk(!mod_reset && !tx_valid && rx_ready, "R8 released and empty",
        {29'd0, mod_reset, tx_valid, rx_ready}, 32'h1);
    bus_read(8'h14, 4'b0011, d, v);
    chk(d == 32'd0, "R8 discarded write", d, 0);

    // random mix against bench queues
    ovf_m = 1'b0; udf_m = 1'b0;
    for (int it = 0; it < 1500; it++) begin
      int op;
      int n;
      op = $urandom_range(0, 6);
      n = ($urandom_range(0, 1) != 0) ? 4 : 2;
      case (op)
        0: begin
          d = $urandom;
          bus_write(8'h01, 4'b0001, d);
          model_write(1, d);
        end
        1: begin
          d = $urandom;
          bus_write(8'h1C, (n == 4) ? 4'b1111 : 4'b0011, d);
          model_write(n, d);
        end
        2: if (txq.size() > 0) tx_take(txq.pop_front(), "R1 R3 random transmit order");
        3: if (rxq.size() < DEPTH) begin
          v = 1'b0;
          d = $urandom;
          rx_send(d[7:0]);
          rxq.push_back(d[7:0]);
        end
        4: begin
          bus_read(8'h01, 4'b0001, d, v);
          model_read(1, e);
          chk(d == e && v, "R2 random byte read", d, e);
        end
        5: begin
          bus_read(8'h1C, (n == 4) ? 4'b1111 : 4'b0011, d, v);
          model_read(n, e);
          chk(d == e, "R4 R7 random packed read", d, e);
        end
        default: begin
          bus_read(8'h10, 4'b1111, d, v);
          chk(d == status_exp(1'b0), "R6 R7 random flags", d, status_exp(1'b0));
          bus_read(8'h14, 4'b0011, d, v);
          chk(d == txq.size(), "R5 random tx level", d, txq.size());
          bus_read(8'h18, 4'b0011, d, v);
          chk(d == rxq.size(), "R5 random rx level", d, rxq.size());
          bus_write(8'h10, 4'b0001, 32'h6);
          ovf_m = 1'b0; udf_m = 1'b0;
        end
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule